// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block decides whether an incoming load can take its data from a small buffer of pending stores. Stores enter at the tail of an eight-entry buffer in program order and leave from the head when a drain strobe reports that the oldest one has retired. Each load gives a byte address and an operand size. The block searches the buffered stores, which are all older than the load, for the youngest one whose byte range overlaps the load.

The block answers with one of three outcomes. The load may be forwarded, with the data aligned to byte 0. The load may be blocked and must wait until the store drains. The load may have no overlapping store, in which case it reads memory.

Forwarding is allowed only when the youngest overlapping store starts at the load's address and is at least as wide as the load. Every other overlap is refused. This includes a narrow store that covers only part of a wider load, and a wide store that the load reads from at an offset. The outcome is registered and appears one cycle after the load is accepted, together with the load's tag.

Top module: `stlf_check`

## Requirements
- R1: While reset is asserted and after it is released, `sb_empty` is 1, `sb_full` is 0 and `rsp_valid` is 0.
- R2: The buffer holds 8 stores. A store with `st_valid` high is written at the tail unless the buffer is full, and a full buffer ignores the store. `sb_full` is 1 when 8 entries are held, and `sb_empty` is 1 when none are held.
- R3: `ld_ready` is low in any cycle in which `st_valid` is high and high otherwise. A load is accepted when `ld_valid` and `ld_ready` are both high. Exactly one cycle after acceptance, `rsp_valid` pulses and `rsp_tag` carries the load's tag.
- R4: The size codes are 0, 1, 2 and 3, meaning 1, 2, 4 and 8 bytes. An access covers the bytes from its address up to address plus size minus 1.
- R5: A load that overlaps no buffered store gets `rsp_kind` 0 (no match), with `rsp_data` equal to 0. A store that ends exactly where the load begins does not overlap it.
- R6: A store with the same start address and the same size as the load gives `rsp_kind` 1 (forward), with the whole store value in the low bytes of `rsp_data`.
- R7: A store wider than the load with the same start address gives `rsp_kind` 1. `rsp_data` holds the low-order bytes of the store data, and the bytes above the load size are zero.
- R8: A store narrower than the load that overlaps it gives `rsp_kind` 2 (blocked).
- R9: A store at least as wide as the load but starting at a different address gives `rsp_kind` 2 when it overlaps the load. This holds even when the load lies wholly inside the store, for example the upper half of the store.
- R10: When several buffered stores overlap the load, only the youngest one decides the outcome.
- R11: A drain strobe while the buffer is empty is ignored. A drain strobe otherwise frees the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Insert a store at the tail |
| st_addr | input | AW | Store byte address |
| st_size | input | 2 | Store size code |
| st_data | input | 64 | Store data, byte 0 in bits 7:0 |
| drain | input | 1 | Free the oldest store |
| sb_full | output | 1 | Buffer holds 8 stores |
| sb_empty | output | 1 | Buffer holds no store |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Load can be accepted this cycle |
| ld_addr | input | AW | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_tag | input | TW | Load identifier |
| rsp_valid | output | 1 | Outcome valid |
| rsp_kind | output | 2 | 0 no match, 1 forward, 2 blocked |
| rsp_data | output | 64 | Forwarded data, zero unless forwarding |
| rsp_tag | output | TW | Tag of the answered load |

## Verification
Single store and load pairs cover every size relation: equal, wider and narrower. Each relation is paired with a start address that is equal, offset inside the range, or just touching the range. This separates the forward cases from the two refusal cases and from the no-overlap case.

Several stacked stores to one address check that the youngest store decides the outcome, both when it permits forwarding and when it refuses it. Filling the buffer past eight entries and draining it while empty show that the ignored operations leave no trace in later load outcomes. A store and a load presented in the same cycle confirm that the load is held back.

// File: rtl/stlf_check.sv
module stlf_check #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int TW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [1:0]    st_size,
  input  logic [63:0]   st_data,
  input  logic          drain,
  output logic          sb_full,
  output logic          sb_empty,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_size,
  input  logic [TW-1:0] ld_tag,
  output logic          rsp_valid,
  output logic [1:0]    rsp_kind,
  output logic [63:0]   rsp_data,
  output logic [TW-1:0] rsp_tag
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] K_NONE = 2'd0, K_FWD = 2'd1, K_BLK = 2'd2;

  logic [AW-1:0] e_addr [DEPTH];
  logic [1:0]    e_size [DEPTH];
  logic [63:0]   e_data [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;

  assign sb_full  = (count == CW'(DEPTH));
  assign sb_empty = (count == '0);
  assign ld_ready = !st_valid;

  wire push = st_valid && !sb_full;
  wire pop  = drain && !sb_empty;
  wire take = ld_valid && ld_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        e_addr[tail] <= st_addr;
        e_size[tail] <= st_size;
        e_data[tail] <= st_data;
        tail <= tail + 1'b1;
      end
      if (pop) head <= head + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  logic [AW:0]   l_lo, l_hi, s_lo, s_hi;
  logic          hit;
  logic [PW-1:0] hidx, idx;

  assign l_lo = {1'b0, ld_addr};
  assign l_hi = l_lo + ((AW+1)'(1) << ld_size);

  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    idx  = '0;
    s_lo = '0;
    s_hi = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx  = head + PW'(i);
      s_lo = {1'b0, e_addr[idx]};
      s_hi = s_lo + ((AW+1)'(1) << e_size[idx]);
      if (i < int'(count) && s_lo < l_hi && l_lo < s_hi) begin
        hit  = 1'b1;
        hidx = idx;
      end
    end
  end

  wire        can_fwd = (e_addr[hidx] == ld_addr) && (e_size[hidx] >= ld_size);
  wire [63:0] ld_mask = (ld_size == 2'd3) ? '1 : ((64'd1 << (6'd8 << ld_size)) - 64'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= K_NONE;
      rsp_data  <= '0;
      rsp_tag   <= '0;
    end else begin
      rsp_valid <= take;
      if (take) begin
        rsp_tag  <= ld_tag;
        rsp_kind <= !hit ? K_NONE : (can_fwd ? K_FWD : K_BLK);
        rsp_data <= (hit && can_fwd) ? (e_data[hidx] & ld_mask) : '0;
      end
    end
  end

  // R2
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sb_full && sb_empty));
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_full && st_valid && !drain) |=> sb_full);
  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_empty && drain && !st_valid) |=> sb_empty);
  // R3
  rsp_follows_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(ld_valid && ld_ready) && rsp_tag == $past(ld_tag)));
  // R5
  kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_kind != 2'd3 && (rsp_kind == K_FWD || rsp_data == '0)));
endmodule

// File: tb/stlf_check_tb.sv
`timescale 1ns/1ps
module stlf_check_tb_top;
  localparam int AW = 16, TW = 4;
  localparam logic [63:0] SD = 64'h8877_6655_4433_2211;

  logic clk = 0, rst_n = 0;
  logic st_valid = 0, drain = 0, ld_valid = 0;
  logic [AW-1:0] st_addr = 0, ld_addr = 0;
  logic [1:0] st_size = 0, ld_size = 0;
  logic [63:0] st_data = 0;
  logic [TW-1:0] ld_tag = 0;
  logic sb_full, sb_empty, ld_ready, rsp_valid;
  logic [1:0] rsp_kind;
  logic [63:0] rsp_data;
  logic [TW-1:0] rsp_tag;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  stlf_check #(.DEPTH(8), .AW(AW), .TW(TW)) dut_i (.*);

  typedef struct packed {
    logic [15:0] sa; logic [1:0] ss;
    logic [15:0] la; logic [1:0] ls;
    logic [1:0] kind; logic [63:0] data; logic [7:0] req;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{16'h10, 2'd2, 16'h10, 2'd2, 2'd1, 64'h44332211, 8'd6},  // R6
    '{16'h20, 2'd3, 16'h20, 2'd3, 2'd1, SD,           8'd6},  // R6
    '{16'h10, 2'd2, 16'h10, 2'd1, 2'd1, 64'h2211,     8'd7},  // R7
    '{16'h10, 2'd3, 16'h10, 2'd0, 2'd1, 64'h11,       8'd7},  // R7
    '{16'h10, 2'd1, 16'h10, 2'd2, 2'd2, 64'h0,        8'd8},  // R8
    '{16'h13, 2'd0, 16'h10, 2'd2, 2'd2, 64'h0,        8'd8},  // R8
    '{16'h10, 2'd2, 16'h12, 2'd1, 2'd2, 64'h0,        8'd9},  // R9
    '{16'h10, 2'd3, 16'h14, 2'd2, 2'd2, 64'h0,        8'd9},  // R9
    '{16'h10, 2'd2, 16'h14, 2'd2, 2'd0, 64'h0,        8'd5},  // R5
    '{16'h10, 2'd2, 16'h0E, 2'd1, 2'd0, 64'h0,        8'd5},  // R5
    '{16'h10, 2'd2, 16'h0F, 2'd1, 2'd2, 64'h0,        8'd9},  // R9
    '{16'h10, 2'd1, 16'h11, 2'd1, 2'd2, 64'h0,        8'd9}   // R9 / R4
  };

  task automatic chk(input int req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic do_store(input logic [15:0] a, input logic [1:0] s, input logic [63:0] d);
    @(negedge clk); st_valid = 1; st_addr = a; st_size = s; st_data = d;
    @(negedge clk); st_valid = 0;
  endtask

  task automatic do_drain(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); drain = 1;
      @(negedge clk); drain = 0;
    end
  endtask

  task automatic do_load(input logic [15:0] a, input logic [1:0] s, input logic [TW-1:0] t,
                         input int req, input logic [1:0] ek, input logic [63:0] ed);
    @(negedge clk); ld_valid = 1; ld_addr = a; ld_size = s; ld_tag = t;
    @(negedge clk); ld_valid = 0;
    chk(req, {62'd0, rsp_kind}, {62'd0, ek});
    chk(req, rsp_data, ed);
    chk(3, {rsp_valid, rsp_tag}, {1'b1, t});
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values while reset is held
    chk(1, {sb_empty, sb_full, rsp_valid}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    // R1: values after reset is released
    chk(1, {sb_empty, sb_full, rsp_valid}, 3'b100);

    foreach (VEC[v]) begin
      do_store(VEC[v].sa, VEC[v].ss, SD);
      do_load(VEC[v].la, VEC[v].ls, TW'(v), int'(VEC[v].req), VEC[v].kind, VEC[v].data);
      do_drain(1);
      chk(2, {63'd0, sb_empty}, 64'd1);
    end

    // R2: fill the buffer; a ninth store is dropped
    for (int k = 0; k < 8; k++) do_store(16'h100 + 16'(8 * k), 2'd3, SD);
    chk(2, {62'd0, sb_full, sb_empty}, 64'b10);
    do_store(16'h200, 2'd3, SD);
    do_load(16'h200, 2'd3, 4'hA, 2, 2'd0, 64'h0);
    do_load(16'h138, 2'd3, 4'hB, 2, 2'd1, SD);
    do_drain(8);
    chk(2, {62'd0, sb_full, sb_empty}, 64'b01);

    // R10: the youngest overlapping store decides
    do_store(16'h40, 2'd2, 64'hAAAA_AAAA);
    do_store(16'h40, 2'd2, 64'h5555_5555);
    do_load(16'h40, 2'd2, 4'h1, 10, 2'd1, 64'h5555_5555);
    do_store(16'h42, 2'd1, 64'h7777);
    do_load(16'h40, 2'd2, 4'h2, 10, 2'd2, 64'h0);
    do_drain(3);

    // R11: drain while empty is ignored
    do_drain(1);
    chk(11, {63'd0, sb_empty}, 64'd1);
    do_store(16'h60, 2'd1, 64'hBEEF);
    chk(11, {63'd0, sb_empty}, 64'd0);
    do_load(16'h60, 2'd1, 4'h3, 11, 2'd1, 64'hBEEF);
    do_drain(1);
    chk(11, {63'd0, sb_empty}, 64'd1);

    // R3: a store in the same cycle holds the load back
    @(negedge clk); st_valid = 1; st_addr = 16'h80; st_size = 2'd0; st_data = 64'h5A;
    ld_valid = 1; ld_addr = 16'h80; ld_size = 2'd0; ld_tag = 4'h9;
    #1 chk(3, {63'd0, ld_ready}, 64'd0);
    @(negedge clk); st_valid = 0;
    chk(3, {63'd0, rsp_valid}, 64'd0);
    #1 chk(3, {63'd0, ld_ready}, 64'd1);
    @(negedge clk); ld_valid = 0;
    chk(3, {rsp_valid, rsp_tag, rsp_kind, rsp_data[7:0]}, {1'b1, 4'h9, 2'd1, 8'h5A});
    @(negedge clk);
    chk(3, {63'd0, rsp_valid}, 64'd0);

    finish_run();
  end
endmodule